// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the device side of a 512-byte memory reached over a two-wire serial bus. A system clock samples both bus lines through synchronisers. The block finds start and stop conditions and shifts in bytes on the rising edge of the clock line. It compares the first byte of each transfer with a fixed four-bit device kind and with two strap inputs. Up to four such devices can therefore share one bus. When the byte matches, the block pulls the data line low for the acknowledge.

A write sends the word address and then one data byte. The byte is stored only when the master closes the transfer with a stop. The stop also starts a fixed internal write time. During that time the block ignores the bus completely. Random reads use a dummy write followed by a repeated start. Current-address and sequential reads return memory bytes most significant bit first. The internal address advances after every byte.

The data line is open drain. The output `sda_oe` high means the block pulls the line low. The memory is a plain register array with no initial contents.

Top module: `tw_mem_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. Data bits are taken on rising SCL, most significant bit first. After reset, `sda_oe` and `busy` are both 0.
- R2: The first byte after a start is accepted only when its bits 7:4 equal 1010 and its bits 3 and 2 equal `strap_a2` and `strap_a1`. A mismatching byte gets no acknowledge, and the block ignores the bus until the next start.
- R3: Bit 1 of the first byte of a write becomes memory address bit 8. The following word-address byte supplies address bits 7:0. Locations that differ only in bit 8 are distinct.
- R4: Bit 0 of the first byte selects the operation: 0 is a write and 1 is a read. In a read, bit 1 has no effect.
- R5: Every accepted byte is acknowledged by `sda_oe` being 1 throughout the ninth SCL high phase. `sda_oe` only rises while SCL is low.
- R6: In a write, the word-address byte and the first data byte are acknowledged. Any further data byte before the stop is not acknowledged and is not stored.
- R7: The data byte is stored only on a stop that follows its acknowledge. A repeated start instead discards it. The storing stop raises `busy` for exactly WR_CYCLES system clocks, and no other event raises `busy`.
- R8: While `busy` is 1, the block never drives the bus, acknowledges nothing and leaves memory unchanged.
- R9: A start or stop inside an unfinished byte abandons the transfer. The current address keeps its earlier value.
- R10: A read returns the byte at the current address, with `sda_oe` equal to the inverse of each bit. The address then advances by one and wraps from 511 to 0. A master acknowledge (SDA low) continues the read. A master non-acknowledge ends it with the bus released. A word-address byte sets the current address. A stored write leaves it at the written location plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired level) |
| strap_a2 | input | 1 | Upper device-select strap |
| strap_a1 | input | 1 | Lower device-select strap |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The hardest states to reach from the ports are the ones where bus traffic overlaps a pending or running write. One is a repeated start after an acknowledged data byte. Another is a new address byte sent while the write timer is still counting. Another is a stop placed in the middle of a word address. The bench gets there by issuing the start immediately after a storing stop, well inside the internal write time. It also sends partial bytes bit by bit before closing them with a stop. Each effect is then confirmed at the ports: the missing acknowledge, and later reads that return the old data and the old current address.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int MEM_BYTES = 512;
  localparam int ADDR_W    = $clog2(MEM_BYTES);
  localparam int BYTE_BITS = 8;
  localparam int BIT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_WADDR, ST_ACK_WA, ST_WDATA,
    ST_ACK_WD, ST_HOLD, ST_RDATA, ST_RACK, ST_BUSY
  } twm_state_e;

  // Selection byte: [7:4] kind, [3] upper strap, [2] lower strap
  function automatic logic dev_match(input logic [BYTE_BITS-1:0] b,
                                     input logic [3:0] kind,
                                     input logic s_hi, input logic s_lo);
    return (b[7:4] == kind) && (b[3] == s_hi) && (b[2] == s_lo);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int PW = 2 * STAGES;

  logic [PW-1:0] pipe;
  logic [1:0]    cur, prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {scl_i, sda_i};
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[PW-3:0], scl_i, sda_i};
    end
  endgenerate

  assign cur = pipe[PW-1 -: 2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 2'b11;
    else        prev <= cur;

  assign scl_s    = cur[1];
  assign sda_s    = cur[0];
  assign ev_start = cur[1] & prev[1] & prev[0] & ~cur[0];
  assign ev_stop  = cur[1] & prev[1] & ~prev[0] & cur[0];
  assign ev_rise  = cur[1] & ~prev[1];
  assign ev_fall  = ~cur[1] & prev[1];
endmodule

// File: rtl/twm_store.sv
module twm_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];
endmodule

// File: rtl/twm_wr_timer.sv
module twm_wr_timer #(
  parameter int CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;

  assign busy = (cnt != '0);
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import twm_pkg::*;
#(
  parameter int         WR_CYCLES   = 600,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_KIND    = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_a2,
  input  logic strap_a1,
  output logic sda_oe,
  output logic busy
);
  // named internal events
  logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;
  logic byte_full, byte_done, dev_ok, commit, busy_w;

  twm_state_e            st;
  logic [BIT_W-1:0]      bitcnt;
  logic [BYTE_BITS-1:0]  shreg, tx, pend_data, rd_byte;
  logic [ADDR_W-1:0]     cur_addr;
  logic                  rd_op, hi_bit, oe_q, rd_more;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  twm_store #(.AW(ADDR_W), .DW(BYTE_BITS)) u_store (
    .clk(clk), .we(commit), .waddr(cur_addr), .wdata(pend_data),
    .raddr(cur_addr), .rdata(rd_byte)
  );

  twm_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy_w)
  );

  assign byte_full = (bitcnt == BIT_W'(BYTE_BITS));
  assign byte_done = ev_fall & byte_full;
  assign dev_ok    = dev_match(shreg, DEV_KIND, strap_a2, strap_a1);
  assign commit    = ev_stop & (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      pend_data <= '0;
      cur_addr  <= '0;
      rd_op     <= 1'b0;
      hi_bit    <= 1'b0;
      oe_q      <= 1'b0;
      rd_more   <= 1'b0;
    end else if (st == ST_BUSY) begin
      if (!busy_w) st <= ST_IDLE;
    end else if (ev_start) begin
      st     <= ST_DEV;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else if (ev_stop) begin
      st   <= commit ? ST_BUSY : ST_IDLE;
      oe_q <= 1'b0;
      if (commit) cur_addr <= addr_step(cur_addr);
    end else begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (ev_rise && !byte_full) begin
            shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (st == ST_DEV) begin
              if (dev_ok) begin
                oe_q   <= 1'b1;
                rd_op  <= shreg[0];
                hi_bit <= shreg[1];
                st     <= ST_ACK_DEV;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              oe_q     <= 1'b1;
              cur_addr <= {hi_bit, shreg};
              st       <= ST_ACK_WA;
            end else begin
              oe_q      <= 1'b1;
              pend_data <= shreg;
              st        <= ST_ACK_WD;
            end
          end
        end
        ST_ACK_DEV: if (ev_fall) begin
          bitcnt <= '0;
          if (rd_op) begin
            tx   <= rd_byte;
            oe_q <= ~rd_byte[BYTE_BITS-1];
            st   <= ST_RDATA;
          end else begin
            oe_q <= 1'b0;
            st   <= ST_WADDR;
          end
        end
        ST_ACK_WA: if (ev_fall) begin
          oe_q <= 1'b0;
          st   <= ST_WDATA;
        end
        ST_ACK_WD: if (ev_fall) begin
          oe_q <= 1'b0;
          st   <= ST_HOLD;
        end
        ST_RDATA: begin
          if (ev_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (ev_fall) begin
            if (byte_full) begin
              oe_q     <= 1'b0;
              cur_addr <= addr_step(cur_addr);
              rd_more  <= 1'b0;
              st       <= ST_RACK;
            end else begin
              tx   <= {tx[BYTE_BITS-2:0], 1'b0};
              oe_q <= ~tx[BYTE_BITS-2];
            end
          end
        end
        ST_RACK: begin
          if (ev_rise) begin
            if (sda_s) st <= ST_IDLE;
            else       rd_more <= 1'b1;
          end else if (ev_fall && rd_more) begin
            tx     <= rd_byte;
            oe_q   <= ~rd_byte[BYTE_BITS-1];
            bitcnt <= '0;
            st     <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;
  assign busy   = busy_w;
endmodule

// File: rtl/twm_checks.sv
module twm_checks
  import twm_pkg::*;
#(
  parameter int WR_CYCLES = 600
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_rise,
  input logic       ev_fall,
  input logic       busy,
  input logic       sda_oe,
  input twm_state_e st
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;

  assert_events_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_stop, ev_rise, ev_fall}));

  assert_silent_when_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  assert_drive_changes_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_busy_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(WR_CYCLES)));

  assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
endmodule

bind tw_mem_slave twm_checks #(.WR_CYCLES(WR_CYCLES)) u_checks (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .ev_start(ev_start),
  .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
  .busy(busy), .sda_oe(sda_oe), .st(st)
);

// File: tb/sim_tw_mem_slave.sv
`timescale 1ns/1ps
module sim_tw_mem_slave;
  localparam int WRC = 600;
  localparam int Q   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic a2 = 1'b1;
  logic a1 = 1'b0;
  logic sda_oe, busy;
  logic sda_line;

  int checks = 0;
  int fails  = 0;
  int brun = 0;
  int last_len = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  tw_mem_slave #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_a2(a2), .strap_a1(a1), .sda_oe(sda_oe), .busy(busy)
  );

  // independent busy-length monitor
  always @(posedge clk) begin
    if (busy) brun <= brun + 1;
    else if (brun != 0) begin last_len <= brun; brun <= 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  function automatic logic [7:0] sel(input logic a8, input logic rw);
    return {4'b1010, a2, a1, a8, rw};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    wq(); sda_m = mack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic wait_idle(input string tag);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(last_len == WRC, tag, last_len, WRC);
  endtask

  task automatic byte_write(input logic [8:0] a, input logic [7:0] d);
    bit k;
    bus_start();
    send_byte(sel(a[8], 1'b0), k); chk(k, "R2 select ack", k, 1);
    send_byte(a[7:0], k);          chk(k, "R6 word address ack", k, 1);
    send_byte(d, k);               chk(k, "R5 data ack", k, 1);
    bus_stop();
    chk(busy == 1'b1, "R7 busy after stop", busy, 1);
    wait_idle("R7 busy length");
  endtask

  task automatic rand_read(input logic [8:0] a, input int n, output logic [7:0] r [2]);
    bit k;
    bus_start();
    send_byte(sel(a[8], 1'b0), k); chk(k, "R3 dummy select ack", k, 1);
    send_byte(a[7:0], k);          chk(k, "R3 dummy word ack", k, 1);
    bus_start();
    send_byte(sel(1'b0, 1'b1), k); chk(k, "R4 read select ack", k, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, r[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
  endtask

  task automatic t_high_bit();
    logic [7:0] r [2];
    byte_write(9'h1A5, 8'h3C);
    byte_write(9'h0A5, 8'h77);
    rand_read(9'h1A5, 1, r); chk(r[0] == 8'h3C, "R3 read 0x1A5", r[0], 8'h3C);
    rand_read(9'h0A5, 1, r); chk(r[0] == 8'h77, "R10 read 0x0A5", r[0], 8'h77);
  endtask

  task automatic t_mismatch();
    bit k;
    bus_start(); send_byte({4'b1010, ~a2, a1, 2'b00}, k); bus_stop();
    chk(!k, "R2 strap mismatch no ack", k, 0);
    bus_start(); send_byte({4'b1011, a2, a1, 2'b00}, k); bus_stop();
    chk(!k, "R2 kind mismatch no ack", k, 0);
  endtask

  task automatic t_busy_deaf();
    bit k;
    logic [7:0] r [2];
    bus_start();
    send_byte(sel(1'b0, 1'b0), k); send_byte(8'h10, k); send_byte(8'h5A, k);
    bus_stop();
    bus_start(); send_byte(sel(1'b0, 1'b0), k); bus_stop();
    chk(!k, "R8 no ack while busy", k, 0);
    chk(busy == 1'b1, "R8 still busy", busy, 1);
    wait_idle("R7 busy length after deaf");
    rand_read(9'h010, 1, r); chk(r[0] == 8'h5A, "R8 memory kept", r[0], 8'h5A);
  endtask

  task automatic t_discard();
    bit k;
    logic [7:0] r;
    byte_write(9'h020, 8'h11);
    bus_start();
    send_byte(sel(1'b0, 1'b0), k); send_byte(8'h20, k); send_byte(8'h99, k);
    chk(k, "R6 data ack before discard", k, 1);
    bus_start();
    send_byte(sel(1'b1, 1'b1), k); chk(k, "R4 read select ack", k, 1);
    recv_byte(1'b0, r); bus_stop();
    chk(r == 8'h11, "R7 repeated start discards", r, 8'h11);
    chk(busy == 1'b0, "R7 no busy without store", busy, 0);
  endtask

  task automatic t_extra();
    bit k;
    logic [7:0] r [2];
    bus_start();
    send_byte(sel(1'b0, 1'b0), k); send_byte(8'h30, k); send_byte(8'h44, k);
    send_byte(8'h55, k); chk(!k, "R6 second data byte no ack", k, 0);
    bus_stop(); wait_idle("R7 busy length extra");
    rand_read(9'h030, 1, r); chk(r[0] == 8'h44, "R6 first byte stored", r[0], 8'h44);
  endtask

  task automatic t_abort();
    bit k;
    logic [7:0] r [2];
    logic [7:0] c;
    byte_write(9'h1A6, 8'hC3);
    rand_read(9'h1A5, 1, r); chk(r[0] == 8'h3C, "R10 read before abort", r[0], 8'h3C);
    bus_start(); send_byte(sel(1'b0, 1'b0), k); send_bits(8'h55, 4); bus_stop();
    bus_start(); send_byte(sel(1'b0, 1'b1), k); recv_byte(1'b0, c); bus_stop();
    chk(c == 8'hC3, "R9 address kept after abort", c, 8'hC3);
  endtask

  task automatic t_wrap();
    logic [7:0] r [2];
    byte_write(9'h1FF, 8'hE1);
    byte_write(9'h000, 8'h2B);
    rand_read(9'h1FF, 2, r);
    chk(r[0] == 8'hE1, "R10 sequential first", r[0], 8'hE1);
    chk(r[1] == 8'h2B, "R10 sequential wraps", r[1], 8'h2B);
    chk(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_high_bit();
    t_mismatch();
    t_busy_deaf();
    t_discard();
    t_extra();
    t_abort();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule